// File: doc/BRIEF.md
# Multiplexed-Bus Burst Read Port

This block is the memory-side read interface for a 16-bit bus on which the same lines carry first an address and then data. It holds a small word array made of registers. During the address phase it captures a word address from the low shared lines and a few upper address pins. It then returns data in one of two ways. In page mode, data comes back at once and follows the two lowest shared lines. In clocked burst mode, data starts after a programmable number of clock edges and then streams either every cycle or every second cycle.

A configuration register chooses among page and burst operation, first-access latency, half-rate streaming and bus inversion. It is loaded through a dedicated write strobe. In burst mode with inversion enabled, the port sends the complement of a word, and flags it, whenever sending it unchanged would flip more than half the lines relative to the word sent before it. A burst walks forward through an aligned 8-word block and wraps inside it. It stops when chip enable is released.

Top module: `mbus_read_port`

## Requirements
- R1: After reset the configuration is page mode, latency 2, full rate and inversion off, with adqOe and binvOut low.
- R2: A rising edge with ceN=0 and advN=0 captures the word address {addrHi, adqIn[3:0]}. The word stored at address a is ((a * 16'h02B5) mod 2^16) XOR 16'hC3A5.
- R3: In page mode, while ceN=0 and advN=1 after a capture, adqOe is 1 and adqOut combinationally shows the word at {captured[5:2], adqIn[1:0]}.
- R4: Configuration write layout: bit0 = page mode (1) / burst (0), bit1 = inversion enable, bit2 = half rate, bits[6:4] = latency code L. In burst mode the first word appears after the L-th rising edge following the capture edge, and adqOe stays 0 before that.
- R5: At full rate a new word follows on every edge. The address increments within its aligned 8-word block and wraps from offset 7 to offset 0.
- R6: At half rate each word is held for two edges.
- R7: A write whose latency code is outside 2..6, or is 5 or 6 while the written half-rate bit is 0, keeps the previous latency, and the other fields are still taken. When the kept latency is 5 or 6, half rate stays 1 even if the write clears it.
- R8: With inversion enabled in burst mode, a word is sent inverted with binvOut=1 when its popcount of differences from the previously sent bus value exceeds 8. The previous value is 0 at each address capture.
- R9: In page mode, or with inversion disabled, binvOut is 0 and data is never inverted.
- R10: With inversion enabled, binvIn=1 during a configuration write inverts the written bits before decode. With inversion disabled, binvIn is ignored, and the address capture always ignores it.
- R11: When ceN is 1, page output stops at once. Burst output and binvOut are low after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| ceN | input | 1 | Active-low chip enable, ends a burst |
| advN | input | 1 | Active-low address phase marker |
| addrHi | input | 2 | Upper word address bits |
| adqIn | input | 16 | Shared lines as seen by the port (address input) |
| adqOut | output | 16 | Data driven onto the shared lines |
| adqOe | output | 1 | Output enable for adqOut |
| binvIn | input | 1 | Inversion flag accompanying written data |
| binvOut | output | 1 | Inversion flag for driven data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWdata | input | 7 | Configuration write data |

## Verification
A wrong wait counter shows at the ports as data arriving one or more edges early or late, so it is seen on the first word of a burst. A broken wrap or increment shows as a wrong word once the burst crosses offset 7 of its block. A lost previous-bus value or a wrong inversion gate shows up as a wrong binvOut or complemented data at the first word whose difference count crosses the threshold. A configuration field that was accepted or rejected wrongly shows up in the timing or rate of the next burst.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  localparam int CFG_W = 7;

  typedef struct packed {
    logic       latch;
    logic       load;
    logic       drop;
    logic       pageOn;
  } strobe_t;

  typedef struct packed {
    logic       pageMode;
    logic       invEn;
    logic       halfRate;
    logic [2:0] latency;
  } cfg_t;

  function automatic logic [15:0] patternWord(input int unsigned a);
    logic [31:0] prod;
    prod = a * 32'h0000_02B5;
    return prod[15:0] ^ 16'hC3A5;
  endfunction

endpackage

// File: rtl/mbus_cfg.sv
module mbus_cfg
  import mbus_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             binvIn,
  output cfg_t             cfg
);

  logic [CFG_W-1:0] effData;
  logic [2:0]       newLat;
  logic             newHalf;
  logic             latOk;
  logic [2:0]       keptLat;

  always_comb begin
    effData = (cfg.invEn && binvIn) ? ~cfgWdata : cfgWdata;
    newLat  = effData[6:4];
    newHalf = effData[2];
    latOk   = ((newLat >= 3'd2) && (newLat <= 3'd4)) ||
              (((newLat == 3'd5) || (newLat == 3'd6)) && newHalf);
    keptLat = latOk ? newLat : cfg.latency;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.pageMode <= 1'b1;
      cfg.invEn    <= 1'b0;
      cfg.halfRate <= 1'b0;
      cfg.latency  <= 3'd2;
    end else if (cfgWe) begin
      cfg.pageMode <= effData[0];
      cfg.invEn    <= effData[1];
      cfg.halfRate <= newHalf || (keptLat >= 3'd5);
      cfg.latency  <= keptLat;
    end
  end

  // R7: the stored latency is always a legal code for the stored rate
  a_r7_latency_legal: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.latency >= 3'd2) && (cfg.latency <= 3'd6) &&
    ((cfg.latency < 3'd5) || cfg.halfRate));

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    advN,
  input  cfg_t    cfg,
  output strobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_PAGE, ST_WAIT, ST_STREAM} state_t;

  state_t     state;
  logic [2:0] waitCnt;
  logic       phase;

  always_comb begin
    strb        = '0;
    strb.pageOn = (state == ST_PAGE) && !ceN && advN;
    if (ceN) begin
      strb.drop = 1'b1;
    end else if (!advN) begin
      strb.latch = 1'b1;
      strb.drop  = 1'b1;
    end else if (state == ST_WAIT && waitCnt == 3'd1) begin
      strb.load = 1'b1;
    end else if (state == ST_STREAM && (!cfg.halfRate || phase)) begin
      strb.load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      phase   <= 1'b0;
    end else if (ceN) begin
      state <= ST_IDLE;
    end else if (!advN) begin
      state   <= cfg.pageMode ? ST_PAGE : ST_WAIT;
      waitCnt <= cfg.latency;
      phase   <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (waitCnt == 3'd1) begin
            state <= ST_STREAM;
            phase <= 1'b0;
          end else begin
            waitCnt <= waitCnt - 3'd1;
          end
        end
        ST_STREAM: phase <= !strb.load;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mbus_datapath.sv
module mbus_datapath
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HI_W   = 2,
  parameter int LO_W   = 4,
  parameter int WRAP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  cfg_t              cfg,
  input  logic [HI_W-1:0]   addrHi,
  input  logic [LO_W-1:0]   adqLo,
  output logic [DATA_W-1:0] adqOut,
  output logic              adqOe,
  output logic              binvOut
);

  localparam int ADDR_W = HI_W + LO_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int HALF   = DATA_W / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrPtr;
  logic [ADDR_W-1:0] nextPtr;
  logic [ADDR_W-1:0] pageAddr;
  logic [DATA_W-1:0] prevBus;
  logic [DATA_W-1:0] outReg;
  logic              outValid;
  logic              binvReg;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] busWord;
  logic              invNow;

  always_comb begin
    curWord  = mem[addrPtr];
    invNow   = cfg.invEn && !cfg.pageMode &&
               ($countones(curWord ^ prevBus) > HALF);
    busWord  = invNow ? ~curWord : curWord;
    nextPtr  = {addrPtr[ADDR_W-1:WRAP_W], addrPtr[WRAP_W-1:0] + 1'b1};
    pageAddr = {addrPtr[ADDR_W-1:2], adqLo[1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= patternWord(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPtr  <= '0;
      prevBus  <= '0;
      outReg   <= '0;
      outValid <= 1'b0;
      binvReg  <= 1'b0;
    end else begin
      if (strb.latch) begin
        addrPtr <= {addrHi, adqLo};
        prevBus <= '0;
      end
      if (strb.load) begin
        outReg   <= busWord;
        binvReg  <= invNow;
        prevBus  <= busWord;
        outValid <= 1'b1;
        addrPtr  <= nextPtr;
      end
      if (strb.drop) begin
        outValid <= 1'b0;
        binvReg  <= 1'b0;
      end
    end
  end

  assign adqOut  = strb.pageOn ? mem[pageAddr] : outReg;
  assign adqOe   = strb.pageOn || outValid;
  assign binvOut = binvReg && outValid;

  // R6: at half rate two loads never come on consecutive edges
  a_r6_half_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && cfg.halfRate) |=> !strb.load);

  // R8 / R9: the inversion flag only appears in burst mode with inversion on
  a_r8_binv_gate: assert property (@(posedge clk) disable iff (!rstN)
    binvOut |-> (cfg.invEn && !cfg.pageMode));

  // R3: page data and registered burst data are never presented together
  a_r3_page_excl: assert property (@(posedge clk) disable iff (!rstN)
    strb.pageOn |-> !outValid);

endmodule

// File: rtl/mbus_read_port.sv
module mbus_read_port
  import mbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HI_W   = 2,
  parameter int LO_W   = 4,
  parameter int WRAP_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              advN,
  input  logic [HI_W-1:0]   addrHi,
  input  logic [DATA_W-1:0] adqIn,
  output logic [DATA_W-1:0] adqOut,
  output logic              adqOe,
  input  logic              binvIn,
  output logic              binvOut,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata
);

  cfg_t    cfg;
  strobe_t strb;

  mbus_cfg u_cfg (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .binvIn   (binvIn),
    .cfg      (cfg)
  );

  mbus_ctrl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ceN  (ceN),
    .advN (advN),
    .cfg  (cfg),
    .strb (strb)
  );

  mbus_datapath #(
    .DATA_W (DATA_W),
    .HI_W   (HI_W),
    .LO_W   (LO_W),
    .WRAP_W (WRAP_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfg     (cfg),
    .addrHi  (addrHi),
    .adqLo   (adqIn[LO_W-1:0]),
    .adqOut  (adqOut),
    .adqOe   (adqOe),
    .binvOut (binvOut)
  );

  // R11: a released chip enable silences the bus after one edge
  a_r11_ce_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> (!adqOe && !binvOut));

endmodule

// File: tb/mbus_read_port_tb.sv
module mbus_read_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1;
  logic        advN = 1'b1;
  logic [1:0]  addrHi = '0;
  logic [15:0] adqIn = '0;
  logic [15:0] adqOut;
  logic        adqOe;
  logic        binvIn = 1'b0;
  logic        binvOut;
  logic        cfgWe = 1'b0;
  logic [6:0]  cfgWdata = '0;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbus_read_port u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .advN(advN), .addrHi(addrHi),
    .adqIn(adqIn), .adqOut(adqOut), .adqOe(adqOe), .binvIn(binvIn),
    .binvOut(binvOut), .cfgWe(cfgWe), .cfgWdata(cfgWdata)
  );

  function automatic logic [15:0] refWord(input int a);
    int p;
    p = a * 'h2B5;
    return p[15:0] ^ 16'hC3A5;
  endfunction

  function automatic int popCount16(input logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += v[i];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [6:0] d, input logic inv);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = d; binvIn = inv;
    @(negedge clk);
    cfgWe = 1'b0; binvIn = 1'b0;
  endtask

  // ends at the negedge right after the capture edge
  task automatic captureAddr(input int a, input logic inv);
    @(negedge clk);
    ceN = 1'b0; advN = 1'b0; binvIn = inv;
    addrHi = a[5:4];
    adqIn = {12'hA5C, a[3:0]};
    @(negedge clk);
    advN = 1'b1; binvIn = 1'b0;
  endtask

  task automatic runBurst(input string req, input int a, input int lat,
                          input bit half, input bit inv, input int n,
                          input logic capInv);
    logic [15:0] prev;
    logic [15:0] w;
    logic [15:0] bus;
    logic        expInv;
    int          addr;
    captureAddr(a, capInv);
    for (int k = 1; k < lat; k++) @(negedge clk);
    check({req, " R4 no data before latency"}, adqOe, 1'b0);
    prev = '0;
    addr = a;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      w = refWord(addr);
      expInv = inv && (popCount16(w ^ prev) > 8);
      bus = expInv ? ~w : w;
      check({req, " R5 word"}, adqOut, bus);
      check({req, " R8 flag"}, binvOut, expInv);
      check({req, " R4 oe"}, adqOe, 1'b1);
      if (half) begin
        @(negedge clk);
        check({req, " R6 held"}, adqOut, bus);
      end
      prev = bus;
      addr = (addr & ~7) | ((addr + 1) & 7);
    end
    ceN = 1'b1;
    @(negedge clk);
    check({req, " R11 burst stop"}, {adqOe, binvOut}, 2'b00);
  endtask

  task automatic pageTest(input string req, input int a);
    captureAddr(a, 1'b0);
    for (int s = 0; s < 4; s++) begin
      adqIn[1:0] = s[1:0];
      #1;
      check({req, " R3 page word"}, adqOut, refWord(((a >> 2) << 2) | s));
      check({req, " R3 oe"}, adqOe, 1'b1);
      check({req, " R9 no flag in page"}, binvOut, 1'b0);
    end
    ceN = 1'b1;
    #1;
    check({req, " R11 page stop"}, adqOe, 1'b0);
  endtask

  task automatic testReset;
    check("R1 oe at reset", adqOe, 1'b0);
    check("R1 binv at reset", binvOut, 1'b0);
    pageTest("R1 default page", 'h35);
  endtask

  task automatic testBurstBasic;
    cfgWrite(7'h20, 1'b0);
    runBurst("R2 lat2", 'h2E, 2, 0, 0, 5, 1'b0);
    cfgWrite(7'h40, 1'b0);
    runBurst("R4 lat4", 'h13, 4, 0, 0, 4, 1'b0);
  endtask

  task automatic testReject;
    cfgWrite(7'h50, 1'b0);
    runBurst("R7 lat5 rejected", 'h08, 4, 0, 0, 3, 1'b0);
    cfgWrite(7'h64, 1'b0);
    runBurst("R6 half lat6", 'h3C, 6, 1, 0, 5, 1'b0);
    cfgWrite(7'h60, 1'b0);
    runBurst("R7 half kept", 'h01, 6, 1, 0, 3, 1'b0);
    cfgWrite(7'h30, 1'b0);
    cfgWrite(7'h72, 1'b0);
    runBurst("R7 code7 R8 invert", 'h28, 3, 0, 1, 8, 1'b0);
  endtask

  task automatic testBinvIn;
    cfgWrite(~7'h20, 1'b1);
    runBurst("R10 inverted write", 'h28, 2, 0, 0, 4, 1'b0);
    cfgWrite(7'h32, 1'b1);
    runBurst("R10 ignored write", 'h28, 3, 0, 1, 4, 1'b1);
    cfgWrite(7'h23, 1'b0);
    pageTest("R9 page with inv", 'h29);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBurstBasic();
    testReject();
    testBinvIn();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule